// File: doc/BRIEF.md
# ATM Idle Cell Generator

This block sits on the transmit side of a cell-based line interface. It keeps the outgoing cell stream running one byte per clock. At each cell boundary it either passes a complete cell from the transmit FIFO or makes an idle cell of its own. Downstream logic treats both kinds of cell the same way. It does not need to know where a cell came from, but a flag marks idle cells for anyone who wants it.

An idle cell is built from a small configuration bank written through an 8-bit data port with a 6-bit register select. The bank holds the four header bytes, a literal fifth byte, one payload fill byte and a control byte. The fifth octet is normally a header error check. This is a CRC-8 over the four programmed header bytes, with an optional coset added. A control bit can switch the check off, and then the programmed fifth byte goes out unaltered. The 48 payload octets all carry the fill byte. The configuration is captured when an idle cell starts, so a write that lands mid-cell shapes only later cells.

The sequencer has three states:
- `ST_WAIT` is the reset state.
- `ST_IDLE` emits an idle cell.
- `ST_FIFO` relays a FIFO cell.

The transitions are:
- `ST_WAIT` → `ST_IDLE` or `ST_FIFO` on the first clock after reset.
- At the last byte of a cell: `ST_IDLE`/`ST_FIFO` → `ST_FIFO` if a cell is available, otherwise → `ST_IDLE`.
- `ST_IDLE`/`ST_FIFO` → same state at every other byte.

Top module: `atm_idle_cell_gen`

## Requirements
- R1: While `rst_n` is low, `out_byte` is 0x00, `out_soc` is 0 and `fifo_rd` is 0, whatever `fifo_cell_avail` shows. The reset configuration is header 00 00 00 01, fifth byte 0x00, fill 0x6A and control 0x03. So the first cell after reset, if idle, is 00 00 00 01 52 followed by 48 bytes of 6A.
- R2: Cells follow one another with no gap. Each cell is exactly 53 bytes long, and `out_soc` is 1 on the first byte only.
- R3: The cell kind is chosen from `fifo_cell_avail` at the clock edge that launches byte 1: 1 gives a FIFO cell and 0 gives an idle cell. `out_idle` is 1 on every byte of an idle cell and 0 on every byte of a FIFO cell. A started cell is never cut short.
- R4: For a FIFO cell, `fifo_rd` is 1 in the cycle that each of its 53 bytes is taken from `fifo_data`, which is first-word-fall-through. The byte present while `fifo_rd` is 1 appears unchanged on `out_byte` one cycle later. An idle cell raises `fifo_rd` on none of its bytes.
- R5: Idle cell bytes 1 to 4 equal the registers at selects 0, 1, 2, 3, in that order.
- R6: Idle cell bytes 6 to 53 all equal the fill register at select 5.
- R7: With control bit 0 set, idle byte 5 is the CRC-8 of bytes 1 to 4. The CRC uses generator x^8+x^2+x+1, zero initial value and MSB first. It is XORed with 0x55 when control bit 1 is set. The control register is at select 6.
- R8: With control bit 0 clear, idle byte 5 equals the register at select 4, unaltered.
- R9: An idle cell uses the configuration held at the edge that launches its byte 1. A write during a cell changes only later cells.
- R10: A write takes effect at the clock edge where `cfg_we` is 1. A write to any select other than 0 to 6 changes nothing visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 6 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| fifo_cell_avail | input | 1 | A complete cell is waiting in the transmit FIFO |
| fifo_data | input | 8 | Head byte of the transmit FIFO (fall-through) |
| fifo_rd | output | 1 | Pop the FIFO head byte at this edge |
| out_byte | output | 8 | Outgoing cell byte |
| out_soc | output | 1 | Marks byte 1 of each cell |
| out_idle | output | 1 | Current cell is an idle cell |

## Verification
The bench builds the block with its default parameters: 53-byte cells, a four-byte header and a 6-bit select. With those values the standard idle header, its 0x52 check byte and the real cell cadence can all be checked directly. A reference CRC written as long division predicts byte 5 for random headers, both with and without the coset. Random choices of cell source and random writes at random selects, made mid-cell, exercise boundary selection, configuration snapshots and ignored selects.

// File: rtl/atm_icg_pkg.sv
package atm_icg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_IDLE = 2'd1,
        ST_FIFO = 2'd2
    } seq_state_e;

    // Control byte bit positions
    localparam int CTL_HEC_EN   = 0;
    localparam int CTL_COSET_EN = 1;

    localparam logic [BYTE_W-1:0] HEC_POLY  = 8'h07;
    localparam logic [BYTE_W-1:0] HEC_COSET = 8'h55;

    // One byte of the serial CRC-8, most significant bit first
    function automatic logic [BYTE_W-1:0] crc8_byte(input logic [BYTE_W-1:0] crc_in,
                                                    input logic [BYTE_W-1:0] din);
        logic [BYTE_W-1:0] c;
        logic              fb;
        c = crc_in;
        for (int b = BYTE_W - 1; b >= 0; b--) begin
            fb = c[BYTE_W-1] ^ din[b];
            c  = {c[BYTE_W-2:0], 1'b0} ^ (fb ? HEC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/icg_cfg_regs.sv
module icg_cfg_regs
    import atm_icg_pkg::*;
#(
    parameter int                          HDR_BYTES = 4,
    parameter int                          SEL_W     = 6,
    parameter logic [HDR_BYTES*BYTE_W-1:0] RST_HDR   = 32'h0000_0001,
    parameter logic [BYTE_W-1:0]           RST_B5    = 8'h00,
    parameter logic [BYTE_W-1:0]           RST_FILL  = 8'h6A,
    parameter logic [BYTE_W-1:0]           RST_CTRL  = 8'h03
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  we,
    input  logic [SEL_W-1:0]                      sel,
    input  logic [BYTE_W-1:0]                     wdata,
    output logic [HDR_BYTES-1:0][BYTE_W-1:0]      hdr_o,
    output logic [BYTE_W-1:0]                     b5_o,
    output logic [BYTE_W-1:0]                     fill_o,
    output logic [BYTE_W-1:0]                     ctrl_o
);

    localparam logic [SEL_W-1:0] SEL_B5   = SEL_W'(HDR_BYTES);
    localparam logic [SEL_W-1:0] SEL_FILL = SEL_W'(HDR_BYTES + 1);
    localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(HDR_BYTES + 2);

    // Header bytes: entry 0 is the first byte on the line
    for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hdr_o[g] <= RST_HDR[(HDR_BYTES-1-g)*BYTE_W +: BYTE_W];
            end else if (we && sel == MY_SEL) begin
                hdr_o[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b5_o   <= RST_B5;
            fill_o <= RST_FILL;
            ctrl_o <= RST_CTRL;
        end else if (we) begin
            if (sel == SEL_B5)   b5_o   <= wdata;
            if (sel == SEL_FILL) fill_o <= wdata;
            if (sel == SEL_CTRL) ctrl_o <= wdata;
        end
    end

    AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel > SEL_CTRL) |=> $stable({hdr_o, b5_o, fill_o, ctrl_o})); // R10

endmodule

// File: rtl/icg_hec_calc.sv
module icg_hec_calc
    import atm_icg_pkg::*;
#(
    parameter int HDR_BYTES = 4
) (
    input  logic [HDR_BYTES-1:0][BYTE_W-1:0] hdr,
    input  logic                             coset_en,
    output logic [BYTE_W-1:0]                hec
);

    logic [BYTE_W-1:0] crc;

    always_comb begin
        crc = '0;
        for (int k = 0; k < HDR_BYTES; k++) begin
            crc = crc8_byte(crc, hdr[k]);
        end
        hec = coset_en ? (crc ^ HEC_COSET) : crc;
    end

endmodule

// File: rtl/icg_cell_seq.sv
module icg_cell_seq
    import atm_icg_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cell_avail,
    input  logic [BYTE_W-1:0]                fifo_data,
    input  logic [HDR_BYTES-1:0][BYTE_W-1:0] live_hdr,
    input  logic [BYTE_W-1:0]                live_b5,
    input  logic [BYTE_W-1:0]                live_fill,
    input  logic [BYTE_W-1:0]                live_ctrl,
    output logic                             fifo_rd,
    output logic [BYTE_W-1:0]                out_byte,
    output logic                             out_soc,
    output logic                             out_idle
);

    localparam int               POS_W   = $clog2(CELL_BYTES);
    localparam logic [POS_W-1:0] LAST    = POS_W'(CELL_BYTES - 1);
    localparam logic [POS_W-1:0] HEC_POS = POS_W'(HDR_BYTES);

    seq_state_e       state, nxt_state;
    logic [POS_W-1:0] pos, pos_nxt;
    logic             boundary;

    // Snapshot of the configuration for the idle cell in flight
    logic [HDR_BYTES-1:0][BYTE_W-1:0] sh_hdr;
    logic [BYTE_W-1:0]                sh_b5, sh_fill, sh_ctrl;
    logic [BYTE_W-1:0]                hec;
    logic [BYTE_W-1:0]                idle_byte;

    assign boundary = (state == ST_WAIT) || (pos == LAST);
    assign pos_nxt  = boundary ? '0 : pos + 1'b1;

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_WAIT: nxt_state = cell_avail ? ST_FIFO : ST_IDLE;
            ST_IDLE,
            ST_FIFO: begin
                if (pos == LAST) nxt_state = cell_avail ? ST_FIFO : ST_IDLE;
            end
            default: nxt_state = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT;
            pos   <= '0;
        end else begin
            state <= nxt_state;
            pos   <= pos_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_hdr  <= '0;
            sh_b5   <= '0;
            sh_fill <= '0;
            sh_ctrl <= '0;
        end else if (boundary && nxt_state == ST_IDLE) begin
            sh_hdr  <= live_hdr;
            sh_b5   <= live_b5;
            sh_fill <= live_fill;
            sh_ctrl <= live_ctrl;
        end
    end

    icg_hec_calc #(.HDR_BYTES(HDR_BYTES)) u_hec (
        .hdr      (sh_hdr),
        .coset_en (sh_ctrl[CTL_COSET_EN]),
        .hec      (hec)
    );

    always_comb begin
        idle_byte = sh_fill;
        if (boundary) begin
            idle_byte = live_hdr[0];
        end else if (pos_nxt == HEC_POS) begin
            idle_byte = sh_ctrl[CTL_HEC_EN] ? hec : sh_b5;
        end else begin
            for (int i = 1; i < HDR_BYTES; i++) begin
                if (pos_nxt == POS_W'(i)) idle_byte = sh_hdr[i];
            end
        end
    end

    assign fifo_rd = rst_n && (nxt_state == ST_FIFO);

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_byte <= '0;
            out_soc  <= 1'b0;
            out_idle <= 1'b0;
        end else begin
            out_byte <= (nxt_state == ST_FIFO) ? fifo_data : idle_byte;
            out_soc  <= boundary;
            out_idle <= (nxt_state == ST_IDLE);
        end
    end

    AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |=> !out_soc); // R2
    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= LAST); // R2
    AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !out_soc |-> $stable(out_idle)); // R3
    AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pos != LAST) |-> !fifo_rd); // R4
    AST_FIFO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> (out_byte == $past(fifo_data) && !out_idle)); // R4

endmodule

// File: rtl/atm_idle_cell_gen.sv
module atm_idle_cell_gen
    import atm_icg_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 4,
    parameter int SEL_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [BYTE_W-1:0] cfg_wdata,
    input  logic              fifo_cell_avail,
    input  logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_soc,
    output logic              out_idle
);

    logic [HDR_BYTES-1:0][BYTE_W-1:0] cfg_hdr;
    logic [BYTE_W-1:0]                cfg_b5, cfg_fill, cfg_ctrl;

    icg_cfg_regs #(
        .HDR_BYTES (HDR_BYTES),
        .SEL_W     (SEL_W)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .hdr_o  (cfg_hdr),
        .b5_o   (cfg_b5),
        .fill_o (cfg_fill),
        .ctrl_o (cfg_ctrl)
    );

    icg_cell_seq #(
        .CELL_BYTES (CELL_BYTES),
        .HDR_BYTES  (HDR_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_avail (fifo_cell_avail),
        .fifo_data  (fifo_data),
        .live_hdr   (cfg_hdr),
        .live_b5    (cfg_b5),
        .live_fill  (cfg_fill),
        .live_ctrl  (cfg_ctrl),
        .fifo_rd    (fifo_rd),
        .out_byte   (out_byte),
        .out_soc    (out_soc),
        .out_idle   (out_idle)
    );

endmodule

// File: tb/tb_atm_idle_cell_gen.sv
`timescale 1ns/1ps
module tb_atm_idle_cell_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic       fifo_cell_avail = 1'b0;
    logic [7:0] fifo_data;
    logic       fifo_rd;
    logic [7:0] out_byte;
    logic       out_soc;
    logic       out_idle;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    atm_idle_cell_gen dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .fifo_cell_avail(fifo_cell_avail),
        .fifo_data(fifo_data), .fifo_rd(fifo_rd), .out_byte(out_byte),
        .out_soc(out_soc), .out_idle(out_idle)
    );

    // FIFO model: head byte counts up on each pop
    logic [7:0] fifo_ptr;
    int         pop_cnt;
    logic       avail_q;
    assign fifo_data = fifo_ptr;
    always @(posedge clk) begin
        if (!rst_n) begin
            fifo_ptr <= 8'h10;
            pop_cnt  <= 0;
        end else if (fifo_rd) begin
            fifo_ptr <= fifo_ptr + 8'd1;
            pop_cnt  <= pop_cnt + 1;
        end
        avail_q <= fifo_cell_avail;
    end

    // Expected configuration after all committed writes
    logic [31:0] m_hdr  = 32'h0000_0001;
    logic [7:0]  m_b5   = 8'h00;
    logic [7:0]  m_fill = 8'h6A;
    logic [7:0]  m_ctrl = 8'h03;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference check byte by polynomial long division
    function automatic logic [7:0] ref_hec(input logic [31:0] h, input logic [7:0] ctl);
        logic [39:0] d;
        d = {h, 8'h00};
        for (int i = 39; i >= 8; i--) begin
            if (d[i]) d[i -: 9] = d[i -: 9] ^ 9'h107;
        end
        return ctl[1] ? (d[7:0] ^ 8'h55) : d[7:0];
    endfunction

    function automatic logic [7:0] ref_idle(input int k, input logic [31:0] h, input logic [7:0] b5,
                                            input logic [7:0] fill, input logic [7:0] ctl);
        if (k < 4)  return h[31 - 8*k -: 8];
        if (k == 4) return ctl[0] ? ref_hec(h, ctl) : b5;
        return fill;
    endfunction

    int  p_prev;
    logic [7:0] fifo_base;

    // Collect one cell starting at the negedge that shows byte 1
    task automatic run_cell(input bit nxt_avail, input bit do_wr, input logic [5:0] sel,
                            input logic [7:0] data, input string over_tag);
        bit          kind_idle;
        logic [31:0] e_hdr;
        logic [7:0]  e_b5, e_fill, e_ctrl, exp_b;
        string       tag;
        kind_idle = !avail_q;
        e_hdr = m_hdr; e_b5 = m_b5; e_fill = m_fill; e_ctrl = m_ctrl;
        chk(out_idle == kind_idle, "R3 cell kind", 32'(out_idle), 32'(kind_idle));
        for (int k = 0; k < 53; k++) begin
            if (k > 0) @(negedge clk);
            chk(out_soc == (k == 0), "R2 start flag", 32'(out_soc), 32'(k == 0));
            chk(out_idle == kind_idle, "R3 kind held", 32'(out_idle), 32'(kind_idle));
            if (kind_idle) begin
                exp_b = ref_idle(k, e_hdr, e_b5, e_fill, e_ctrl);
                if (k < 4) tag = "R5 header";
                else if (k == 4) tag = e_ctrl[0] ? "R7 hec" : "R8 hec bypass";
                else tag = "R6 payload";
                if (do_wr && k > 31) tag = "R9 snapshot";
                if (over_tag != "") tag = over_tag;
            end else begin
                exp_b = fifo_base + 8'(k);
                tag = "R4 fifo byte";
            end
            chk(out_byte == exp_b, tag, 32'(out_byte), 32'(exp_b));
            if (k == 30 && do_wr) begin
                cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
            end
            if (k == 31 && do_wr) begin
                cfg_we = 1'b0;
                case (sel)
                    6'd0: m_hdr[31:24] = data;
                    6'd1: m_hdr[23:16] = data;
                    6'd2: m_hdr[15:8]  = data;
                    6'd3: m_hdr[7:0]   = data;
                    6'd4: m_b5   = data;
                    6'd5: m_fill = data;
                    6'd6: m_ctrl = data;
                    default: ;
                endcase
            end
            if (k == 50) fifo_cell_avail = nxt_avail;
        end
        chk((pop_cnt - p_prev) == (kind_idle ? 0 : 53), "R4 pop count",
            32'(pop_cnt - p_prev), kind_idle ? 32'd0 : 32'd53);
        p_prev    = pop_cnt;
        fifo_base = fifo_ptr;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fifo_cell_avail = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(out_byte == 8'h00 && !out_soc && !fifo_rd, "R1 reset outputs",
                {out_byte, 7'd0, out_soc, 7'd0, fifo_rd}, 32'd0);
        end
        fifo_cell_avail = 1'b0;
        p_prev    = 0;
        fifo_base = 8'h10;
        rst_n = 1'b1;
        @(negedge clk);
        // First cell: reset defaults, expected 00 00 00 01 52 6A...
        chk(ref_hec(32'h0000_0001, 8'h03) == 8'h52, "R7 reference hec", 32'(ref_hec(32'h1, 8'h3)), 32'h52);
        run_cell(1'b0, 1'b1, 6'd4, 8'hA5, "R1 defaults");
        run_cell(1'b0, 1'b1, 6'd6, 8'h00, "");            // R8 bypass next
        run_cell(1'b0, 1'b1, 6'd6, 8'h01, "");            // R8 checked, R7 without coset next
        run_cell(1'b0, 1'b1, 6'd5, 8'h3C, "");            // R7 no coset, R9 fill write
        run_cell(1'b0, 1'b1, 6'd63, 8'hFF, "");           // R10 bad select
        run_cell(1'b1, 1'b1, 6'd7, 8'h00, "R10 ignored"); // R10 observed here
        run_cell(1'b1, 1'b1, 6'd0, 8'hC3, "");            // FIFO cell, R3
        run_cell(1'b0, 1'b0, 6'd0, 8'h00, "");            // FIFO again
        run_cell(1'b0, 1'b1, 6'd6, 8'h03, "");
        for (int c = 0; c < 60; c++) begin
            logic [5:0] s;
            s = ($urandom % 4 == 0) ? 6'($urandom % 64) : 6'($urandom % 8);
            run_cell(1'($urandom % 2), 1'($urandom % 3 != 0), s, 8'($urandom), "");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule